// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 32 by 32 pixel, two-colour pointer image over a video stream. For each pixel the display pipeline supplies the beam column and line, the colour already chosen for that position, and the two cursor colours taken from the overlay palette. The block returns either the incoming colour or one of the two cursor colours, one clock later.

Software controls the pointer through a small word-addressed register window. One word sets the packed position. One table of 32 words sets which pixels of each cursor row are opaque, and a second table of 32 words picks the colour of each opaque pixel. A scratch word can be written and read back with a fixed flag bit set. Every other read returns zero. The cursor is clipped at the right edge of the active picture. Out of reset it sits far off-screen.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor position is column 0xF000, line 0xF000, and every row's opacity and colour words are zero. A beam anywhere below 0xF000 in either axis sees its input colour unchanged, and `reg_rdata` is zero.
- R2: A write to offset 0x8FC loads the cursor column from data bits 31:16 and the cursor line from bits 15:0.
- R3: Cursor row r takes its opacity word from a write to offset 0x900 + 4*r and its colour-select word from a write to offset 0x980 + 4*r, for r = 0..31.
- R4: Within a row, bit 31 belongs to the pixel at the cursor column, and the pixel k columns to its right uses bit 31-k.
- R5: A pixel whose opacity bit is 0 outputs `pix_in` unchanged.
- R6: A pixel whose opacity bit is 1 outputs `shade_hi` when its colour-select bit is 1 and `shade_lo` when that bit is 0.
- R7: The cursor covers only lines cursor_y to cursor_y+31 and columns cursor_x to cursor_x+31. Outside that window the output is `pix_in`.
- R8: Nothing is drawn when cursor_x is not less than `act_width`, and columns at or beyond `act_width` always output `pix_in`.
- R9: A write to offset 0x818 stores the word. A read of 0x818 returns it with bit 25 forced to 1 on `reg_rdata` in the cycle after the read strobe.
- R10: A read of any offset other than 0x818, including the position and table offsets, returns zero in the cycle after the strobe.
- R11: The pixel path has exactly one register: `pix_out` reflects the inputs present at the previous rising clock edge.
- R12: A write to an offset outside the position, scratch and table ranges changes no register and no pixel result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 12 | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Register read strobe |
| reg_raddr | input | 12 | Read byte offset |
| reg_rdata | output | 32 | Read data, valid one cycle after the strobe |
| act_width | input | 16 | Active picture width in pixels |
| beam_x | input | 16 | Current pixel column |
| beam_y | input | 16 | Current pixel line |
| pix_in | input | 24 | Underlying pixel colour |
| shade_lo | input | 24 | Cursor colour for opaque pixels with select bit 0 |
| shade_hi | input | 24 | Cursor colour for opaque pixels with select bit 1 |
| pix_out | output | 24 | Composited colour, registered |

## Verification
The hardest case to reach from the ports is the reset position, because 0xF000 is far past any real picture. The stimulus first loads an all-opaque row 0 without moving the cursor, widens the active width to its maximum, and steers the beam to exactly (0xF000, 0xF000) and one column short of it. A second hard area is the right edge. There the test shrinks `act_width` step by step across a row whose select bits alternate, so that a clipped pixel and an unclipped one give different colours.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  // Source of the composited pixel
  typedef enum logic [1:0] {
    SRC_PASS = 2'd0,
    SRC_LO   = 2'd1,
    SRC_HI   = 2'd2
  } pix_src_e;

  localparam int unsigned REG_ADDR_W = 12;

  // Offsets decoded by the register file (software depends on these)
  localparam logic [REG_ADDR_W-1:0] OFS_SCRATCH = 12'h818;
  localparam logic [REG_ADDR_W-1:0] OFS_POS     = 12'h8FC;
  localparam logic [REG_ADDR_W-1:0] OFS_OPAQUE  = 12'h900;
  localparam logic [REG_ADDR_W-1:0] OFS_SELECT  = 12'h980;

  localparam int unsigned SCRATCH_FLAG_BIT = 25;
  localparam logic [15:0] POS_PARK         = 16'hF000;

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 16,
  localparam int ROWS   = DATA_W,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int AW     = REG_ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic [COORD_W-1:0] cur_x,
  output logic [COORD_W-1:0] cur_y,
  input  logic [ROW_W-1:0]   row_sel,
  output logic [DATA_W-1:0]  row_opaque,
  output logic [DATA_W-1:0]  row_select
);

  localparam logic [AW-1:0] TABLE_SPAN = AW'(ROWS * 4);

  function automatic logic in_table(input logic [AW-1:0] a, input logic [AW-1:0] base);
    return (a >= base) && (a < base + TABLE_SPAN);
  endfunction

  function automatic logic [ROW_W-1:0] table_row(input logic [AW-1:0] a, input logic [AW-1:0] base);
    logic [AW-1:0] diff;
    diff = (a - base) >> 2;
    return diff[ROW_W-1:0];
  endfunction

  // Decoded write events
  logic pos_we, scratch_we, opaque_we, select_we, wr_unmapped;
  logic [ROW_W-1:0] wr_row;

  assign pos_we      = wr_en && (wr_addr == OFS_POS);
  assign scratch_we  = wr_en && (wr_addr == OFS_SCRATCH);
  assign opaque_we   = wr_en && in_table(wr_addr, OFS_OPAQUE);
  assign select_we   = wr_en && in_table(wr_addr, OFS_SELECT);
  assign wr_unmapped = wr_en && !(pos_we || scratch_we || opaque_we || select_we);
  assign wr_row      = opaque_we ? table_row(wr_addr, OFS_OPAQUE)
                                 : table_row(wr_addr, OFS_SELECT);

  logic [DATA_W-1:0] opaque_q [ROWS];
  logic [DATA_W-1:0] select_q [ROWS];
  logic [DATA_W-1:0] scratch_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        opaque_q[r] <= '0;
        select_q[r] <= '0;
      end else begin
        if (opaque_we && (wr_row == ROW_W'(r))) opaque_q[r] <= wr_data;
        if (select_we && (wr_row == ROW_W'(r))) select_q[r] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_x     <= POS_PARK;
      cur_y     <= POS_PARK;
      scratch_q <= '0;
    end else begin
      if (pos_we) begin
        cur_x <= wr_data[DATA_W-1 -: COORD_W];
        cur_y <= wr_data[COORD_W-1:0];
      end
      if (scratch_we) scratch_q <= wr_data;
    end
  end

  // Read path: only the scratch word is visible
  logic rd_scratch;
  assign rd_scratch = rd_en && (rd_addr == OFS_SCRATCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_scratch ? (scratch_q | (DATA_W'(1) << SCRATCH_FLAG_BIT)) : '0;
    end
  end

  assign row_opaque = opaque_q[row_sel];
  assign row_select = select_q[row_sel];

  assert_scratch_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_scratch |=> rd_data[SCRATCH_FLAG_BIT]);

  assert_other_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_scratch) |=> (rd_data == '0));

  assert_pos_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_we |=> (cur_y == $past(wr_data[COORD_W-1:0])) &&
               (cur_x == $past(wr_data[DATA_W-1 -: COORD_W])));

  assert_unmapped_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> $stable(cur_x) && $stable(cur_y) && $stable(scratch_q));

endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
  import cursor_pkg::*;
#(
  parameter int DIM     = 32,
  parameter int COORD_W = 16,
  localparam int ROW_W  = $clog2(DIM)
) (
  input  logic [COORD_W-1:0] beam_x,
  input  logic [COORD_W-1:0] beam_y,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  input  logic [COORD_W-1:0] act_width,
  input  logic [DIM-1:0]     row_opaque,
  input  logic [DIM-1:0]     row_select,
  output logic [ROW_W-1:0]   row_sel,
  output logic               in_rows,
  output logic               in_cols,
  output logic               visible,
  output logic               opaque_bit,
  output logic               select_bit,
  output pix_src_e           src
);

  localparam logic [ROW_W-1:0] LAST_BIT = ROW_W'(DIM - 1);

  // beam minus origin, with a borrow bit on top
  function automatic logic [COORD_W:0] span_ofs(input logic [COORD_W-1:0] beam,
                                                 input logic [COORD_W-1:0] origin);
    return {1'b0, beam} - {1'b0, origin};
  endfunction

  function automatic logic in_span(input logic [COORD_W:0] ofs);
    return !ofs[COORD_W] && (ofs[COORD_W-1:0] < COORD_W'(DIM));
  endfunction

  logic [COORD_W:0] row_ofs, col_ofs;
  logic [ROW_W-1:0] bit_pos;

  assign row_ofs = span_ofs(beam_y, cur_y);
  assign col_ofs = span_ofs(beam_x, cur_x);
  assign in_rows = in_span(row_ofs);
  assign in_cols = in_span(col_ofs);
  assign row_sel = row_ofs[ROW_W-1:0];

  // leftmost pixel uses the top bit
  assign bit_pos    = LAST_BIT - col_ofs[ROW_W-1:0];
  assign opaque_bit = row_opaque[bit_pos];
  assign select_bit = row_select[bit_pos];

  assign visible = in_rows && in_cols && (cur_x < act_width) && (beam_x < act_width);

  always_comb begin
    if (!visible || !opaque_bit) src = SRC_PASS;
    else if (select_bit)         src = SRC_HI;
    else                         src = SRC_LO;
  end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 16,
  parameter int COLOR_W = 24,
  localparam int DIM    = DATA_W,
  localparam int ROW_W  = $clog2(DIM)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_waddr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic                  reg_rd,
  input  logic [REG_ADDR_W-1:0] reg_raddr,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [COORD_W-1:0]    act_width,
  input  logic [COORD_W-1:0]    beam_x,
  input  logic [COORD_W-1:0]    beam_y,
  input  logic [COLOR_W-1:0]    pix_in,
  input  logic [COLOR_W-1:0]    shade_lo,
  input  logic [COLOR_W-1:0]    shade_hi,
  output logic [COLOR_W-1:0]    pix_out
);

  logic [COORD_W-1:0] cur_x, cur_y;
  logic [ROW_W-1:0]   row_sel;
  logic [DIM-1:0]     row_opaque, row_select;
  logic               in_rows, in_cols, visible, opaque_bit, select_bit;
  pix_src_e           src;

  cursor_regs #(.DATA_W(DATA_W), .COORD_W(COORD_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .wr_addr    (reg_waddr),
    .wr_data    (reg_wdata),
    .rd_en      (reg_rd),
    .rd_addr    (reg_raddr),
    .rd_data    (reg_rdata),
    .cur_x      (cur_x),
    .cur_y      (cur_y),
    .row_sel    (row_sel),
    .row_opaque (row_opaque),
    .row_select (row_select)
  );

  cursor_hit #(.DIM(DIM), .COORD_W(COORD_W)) u_hit (
    .beam_x     (beam_x),
    .beam_y     (beam_y),
    .cur_x      (cur_x),
    .cur_y      (cur_y),
    .act_width  (act_width),
    .row_opaque (row_opaque),
    .row_select (row_select),
    .row_sel    (row_sel),
    .in_rows    (in_rows),
    .in_cols    (in_cols),
    .visible    (visible),
    .opaque_bit (opaque_bit),
    .select_bit (select_bit),
    .src        (src)
  );

  // Single output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out <= '0;
    end else begin
      unique case (src)
        SRC_HI:  pix_out <= shade_hi;
        SRC_LO:  pix_out <= shade_lo;
        default: pix_out <= pix_in;
      endcase
    end
  end

  assert_outside_rows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rows |=> (pix_out == $past(pix_in)));

  assert_right_clip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_x >= act_width) |=> (pix_out == $past(pix_in)));

  assert_clear_bit_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (visible && !opaque_bit) |=> (pix_out == $past(pix_in)));

  assert_shade_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (visible && opaque_bit) |=>
      (pix_out == ($past(select_bit) ? $past(shade_hi) : $past(shade_lo))));

endmodule

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [11:0] reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic [15:0] act_width = 16'd640;
  logic [15:0] beam_x = '0;
  logic [15:0] beam_y = '0;
  logic [23:0] pix_in = '0;
  logic [23:0] shade_lo = 24'h1111EE;
  logic [23:0] shade_hi = 24'hEEEE11;
  logic [23:0] pix_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  cursor_overlay u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .act_width(act_width), .beam_x(beam_x), .beam_y(beam_y),
    .pix_in(pix_in), .shade_lo(shade_lo), .shade_hi(shade_hi),
    .pix_out(pix_out)
  );

  // code: 0 = input colour, 1 = shade_lo, 2 = shade_hi
  // cursor at (100,50); row0 opaque 8000_0001 select 8000_0000;
  // row1 opaque 4000_0000 select all ones; row31 opaque all ones select 5555_5555
  localparam logic [33:0] VECS [12] = '{
    {16'd100, 16'd50, 2'd2},  // R4 R6 leftmost bit
    {16'd131, 16'd50, 2'd1},  // R4 R6 rightmost bit
    {16'd115, 16'd50, 2'd0},  // R5 clear bit
    {16'd99,  16'd50, 2'd0},  // R7 left of window
    {16'd132, 16'd50, 2'd0},  // R7 right of window
    {16'd100, 16'd49, 2'd0},  // R7 above
    {16'd100, 16'd81, 2'd1},  // R3 R6 row 31
    {16'd101, 16'd81, 2'd2},  // R4 second pixel
    {16'd100, 16'd82, 2'd0},  // R7 below
    {16'd101, 16'd51, 2'd2},  // R3 row 1
    {16'd100, 16'd51, 2'd0},  // R5 row 1
    {16'd110, 16'd55, 2'd0}   // R5 untouched row
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_raddr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rdata, exp, tag);
  endtask

  task automatic px(input logic [15:0] x, input logic [15:0] y,
                    input logic [1:0] code, input string tag);
    logic [23:0] exp;
    @(negedge clk);
    beam_x = x; beam_y = y; pix_in = {8'h5A, x[7:0], y[7:0]};
    exp = (code == 2'd2) ? shade_hi : (code == 2'd1) ? shade_lo : pix_in;
    @(negedge clk);
    check({8'h0, pix_out}, {8'h0, exp}, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(reg_rdata, 32'h0, "R1 rdata after reset");
    px(16'd0, 16'd0, 2'd0, "R1 origin passes");
    rd(12'h818, 32'h0200_0000, "R1 R9 scratch reset read");

    // R1 parked position: load row 0 without moving the cursor
    wr(12'h900, 32'hFFFF_FFFF);
    wr(12'h980, 32'hFFFF_FFFF);
    act_width = 16'hFFFF;
    px(16'hF000, 16'hF000, 2'd2, "R1 parked cursor at F000");
    px(16'hEFFF, 16'hF000, 2'd0, "R1 left of parked cursor");
    px(16'h0010, 16'h0000, 2'd0, "R1 on-screen clear");

    // R2 R3 set up the pattern for the table
    act_width = 16'd640;
    wr(12'h8FC, 32'h0064_0032);
    wr(12'h900, 32'h8000_0001);
    wr(12'h980, 32'h8000_0000);
    wr(12'h904, 32'h4000_0000);
    wr(12'h984, 32'hFFFF_FFFF);
    wr(12'h97C, 32'hFFFF_FFFF);
    wr(12'h9FC, 32'h5555_5555);

    for (int i = 0; i < 12; i++)
      px(VECS[i][33:18], VECS[i][17:2], VECS[i][1:0], "R2 R4 R5 R6 R7 table");

    // R11 one register: the output holds until the next edge
    px(16'd100, 16'd50, 2'd2, "R11 setup");
    @(negedge clk);
    beam_x = 16'd99; pix_in = 24'h123456;
    #1 check({8'h0, pix_out}, {8'h0, shade_hi}, "R11 holds before edge");
    @(negedge clk);
    check({8'h0, pix_out}, 32'h0012_3456, "R11 updates after edge");

    // R8 right-edge clipping on row 31 (alternating select bits)
    act_width = 16'd120;
    px(16'd119, 16'd81, 2'd2, "R8 last column inside");
    px(16'd120, 16'd81, 2'd0, "R8 column at width clipped");
    act_width = 16'd101;
    px(16'd100, 16'd81, 2'd1, "R8 cursor x just below width");
    act_width = 16'd100;
    px(16'd100, 16'd81, 2'd0, "R8 cursor x at width");
    act_width = 16'd640;

    // R9 scratch
    wr(12'h818, 32'h0000_1234);
    rd(12'h818, 32'h0200_1234, "R9 scratch readback");

    // R10 other reads
    rd(12'h8FC, 32'h0, "R10 position read zero");
    rd(12'h900, 32'h0, "R10 table read zero");

    // R12 unmapped writes
    wr(12'hA00, 32'hFFFF_FFFF);
    wr(12'h814, 32'h0000_0000);
    wr(12'h8F8, 32'h0000_0000);
    rd(12'h818, 32'h0200_1234, "R12 scratch untouched");
    px(16'd100, 16'd50, 2'd2, "R12 cursor unmoved");
    px(16'd115, 16'd50, 2'd0, "R12 row 0 unchanged");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule